// File: doc/BRIEF.md
# Programmable clock output divider and selector

This block produces the two clock outputs of a clock source. The main output is a fast oscillator clock divided by an integer ratio. A 3-bit select code chooses the ratio from a fixed set of eight: 2, 3, 4, 5, 6, 7, 8 and 10. The codes do not map to the ratios in ascending order. The auxiliary output is picked by a 2-bit function code. It can be the reference clock, the reference clock halved, a constant low, or the main output halved.

A bypass input sends the reference clock straight to both outputs. It is driven when the upstream reference divider word is zero. An active-low power-down input silences both outputs and drops the pad drive enable, so the pad ring floats the pins.

The block is built as a down-stream stage of a frequency synthesizer, and all controls come from an already latched configuration word. Every pin is a plain clock or control level. There is no data stream, so no valid/ready handshake exists and nothing is back-pressured. A new select code is adopted only at a period boundary, so changing the ratio never cuts a period short.

Top module: `clk_out_divsel`

## Requirements
- R1: The select code `div_sel` sets the main divide ratio N: 000→10, 001→2, 010→8, 011→4, 100→5, 101→7, 110→3, 111→6. The main output period is N cycles of `vco_clk`.
- R2: Each main output period starts high. The output is high for floor(N/2) oscillator cycles and low for ceil(N/2) cycles. Even ratios therefore give 50 % duty, and odd ratios give (N-1)/2 high and (N+1)/2 low.
- R3: A change of `div_sel` takes effect only at the end of the current main period. The running period completes with its old ratio, and the next period uses the new one.
- R4: With `aux_func` = 00, the auxiliary output equals `ref_clk`.
- R5: With `aux_func` = 01, the auxiliary output is a reference half-rate clock. It is low after reset and toggles on every rising edge of `ref_clk`.
- R6: With `aux_func` = 10, the auxiliary output is held low.
- R7: With `aux_func` = 11, the auxiliary output is the main output halved. It toggles at the start of every main period, which gives N cycles high and N cycles low for any N.
- R8: When `pll_bypass` is 1, both outputs equal `ref_clk`, whatever the select and function codes are.
- R9: When `pd_n` is 0, both outputs are 0 and `pad_oe_o` is 0. When `pd_n` is 1, `pad_oe_o` is 1.
- R10: While `rst_n` is low, the main output and the main half-rate output are low. The first rising `vco_clk` edge after release starts a high period that uses the select code present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast oscillator clock that is divided |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 3 | Main divide ratio select code |
| aux_func | input | 2 | Auxiliary output source code |
| pll_bypass | input | 1 | 1: both outputs carry the reference clock |
| pd_n | input | 1 | Active-low power-down |
| main_clk_o | output | 1 | Main clock output |
| aux_clk_o | output | 1 | Auxiliary clock output |
| pad_oe_o | output | 1 | Output pad drive enable |

## Verification
The divided main output and its half-rate copy change on the same rising `vco_clk` edge that starts a period, with one register in the path. The bench therefore samples them on the falling edge that follows and counts run lengths in whole oscillator cycles. The reference, bypass, held-low and power-down paths are combinational and are checked at the same falling edges. The reference edges are placed half a nanosecond off the sampling grid, so no sample lands on a reference transition. For the reference half-rate output, the bench counts `ref_clk` rising edges since reset. A select change is applied on the falling edge right after a period has begun, and the next two periods are then measured, so the old ratio is due for exactly one more period.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/100ps
package clkdiv_pkg;
  localparam int SEL_W   = 3;
  localparam int FUNC_W  = 2;
  localparam int RATIO_W = 4;

  typedef enum logic [FUNC_W-1:0] {
    AUX_REF      = 2'b00,
    AUX_REF_HALF = 2'b01,
    AUX_LOW      = 2'b10,
    AUX_MAIN_HALF= 2'b11
  } aux_src_e;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [SEL_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      3'b000:  r = 4'd10;
      3'b001:  r = 4'd2;
      3'b010:  r = 4'd8;
      3'b011:  r = 4'd4;
      3'b100:  r = 4'd5;
      3'b101:  r = 4'd7;
      3'b110:  r = 4'd3;
      default: r = 4'd6;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clkdiv_counter.sv
`timescale 1ns/100ps
module clkdiv_counter
  import clkdiv_pkg::*;
#(
  parameter logic [SEL_W-1:0] RESET_SEL = 3'b011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   sel,
  output logic               div_o,
  output logic               wrap_o,
  output logic [RATIO_W-1:0] cnt_o,
  output logic [RATIO_W-1:0] ratio_o
);
  localparam logic [RATIO_W-1:0] RST_RATIO = ratio_of(RESET_SEL);
  localparam logic [RATIO_W-1:0] ONE       = {{(RATIO_W-1){1'b0}}, 1'b1};

  logic [RATIO_W-1:0] cnt_q, cnt_n;
  logic [RATIO_W-1:0] ratio_q, ratio_n;
  logic               div_q, div_n;
  logic               wrap;

  always_comb begin
    wrap = (cnt_q == ratio_q - ONE);
    if (wrap) begin
      cnt_n   = '0;
      ratio_n = ratio_of(sel);
    end else begin
      cnt_n   = cnt_q + ONE;
      ratio_n = ratio_q;
    end
    div_n = (cnt_n < (ratio_n >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= RST_RATIO - ONE;
      ratio_q <= RST_RATIO;
      div_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      ratio_q <= ratio_n;
      div_q   <= div_n;
    end
  end

  assign div_o   = div_q;
  assign wrap_o  = wrap;
  assign cnt_o   = cnt_q;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/clkdiv_toggle.sv
`timescale 1ns/100ps
module clkdiv_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic q
);
  logic q_r;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= 1'b0;
    else if (en) q_r <= ~q_r;
  end
  assign q = q_r;
endmodule

// File: rtl/clkdiv_outmux.sv
`timescale 1ns/100ps
module clkdiv_outmux
  import clkdiv_pkg::*;
(
  input  logic              ref_clk,
  input  logic              ref_half,
  input  logic              main_div,
  input  logic              main_half,
  input  logic [FUNC_W-1:0] func,
  input  logic              bypass,
  input  logic              pd_n,
  output logic              main_o,
  output logic              aux_o,
  output logic              oe_o
);
  logic main_sel, aux_sel;

  always_comb begin
    case (aux_src_e'(func))
      AUX_REF:       aux_sel = ref_clk;
      AUX_REF_HALF:  aux_sel = ref_half;
      AUX_LOW:       aux_sel = 1'b0;
      default:       aux_sel = main_half;
    endcase
    main_sel = main_div;
    if (bypass) begin
      main_sel = ref_clk;
      aux_sel  = ref_clk;
    end
    main_o = pd_n & main_sel;
    aux_o  = pd_n & aux_sel;
    oe_o   = pd_n;
  end
endmodule

// File: rtl/clk_out_divsel.sv
`timescale 1ns/100ps
module clk_out_divsel
  import clkdiv_pkg::*;
#(
  parameter logic [SEL_W-1:0] RESET_SEL = 3'b011
) (
  input  logic              vco_clk,
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  div_sel,
  input  logic [FUNC_W-1:0] aux_func,
  input  logic              pll_bypass,
  input  logic              pd_n,
  output logic              main_clk_o,
  output logic              aux_clk_o,
  output logic              pad_oe_o
);
  logic               div_q;
  logic               div_wrap;
  logic [RATIO_W-1:0] div_cnt;
  logic [RATIO_W-1:0] div_ratio;
  logic               main_half;
  logic               ref_half;

  clkdiv_counter #(.RESET_SEL(RESET_SEL)) u_cnt (
    .clk     (vco_clk),
    .rst_n   (rst_n),
    .sel     (div_sel),
    .div_o   (div_q),
    .wrap_o  (div_wrap),
    .cnt_o   (div_cnt),
    .ratio_o (div_ratio)
  );

  clkdiv_toggle u_main_half (
    .clk   (vco_clk),
    .rst_n (rst_n),
    .en    (div_wrap),
    .q     (main_half)
  );

  clkdiv_toggle u_ref_half (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .en    (1'b1),
    .q     (ref_half)
  );

  clkdiv_outmux u_mux (
    .ref_clk   (ref_clk),
    .ref_half  (ref_half),
    .main_div  (div_q),
    .main_half (main_half),
    .func      (aux_func),
    .bypass    (pll_bypass),
    .pd_n      (pd_n),
    .main_o    (main_clk_o),
    .aux_o     (aux_clk_o),
    .oe_o      (pad_oe_o)
  );
endmodule

// File: rtl/clk_out_divsel_chk.sv
`timescale 1ns/100ps
module clk_out_divsel_chk
  import clkdiv_pkg::*;
(
  input logic               vco_clk,
  input logic               rst_n,
  input logic [RATIO_W-1:0] div_cnt,
  input logic [RATIO_W-1:0] div_ratio,
  input logic               div_q,
  input logic               main_half,
  input logic [FUNC_W-1:0]  aux_func,
  input logic               pll_bypass,
  input logic               pd_n,
  input logic               main_clk_o,
  input logic               aux_clk_o,
  input logic               pad_oe_o
);
  assert_cnt_in_range_R1: assert property (@(posedge vco_clk) disable iff (!rst_n)
    div_cnt < div_ratio);

  assert_period_starts_high_R2: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (div_cnt == '0) |-> div_q);

  assert_ratio_only_at_wrap_R3: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !$stable(div_ratio) |-> ($past(div_cnt) == $past(div_ratio) - 4'd1));

  assert_aux_low_R6: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (aux_func == 2'b10 && !pll_bypass) |-> !aux_clk_o);

  assert_half_on_rise_R7: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !$stable(main_half) |-> $rose(div_q));

  assert_powerdown_quiet_R9: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !pd_n |-> (!pad_oe_o && !main_clk_o && !aux_clk_o));
endmodule

bind clk_out_divsel clk_out_divsel_chk chk_i (
  .vco_clk    (vco_clk),
  .rst_n      (rst_n),
  .div_cnt    (div_cnt),
  .div_ratio  (div_ratio),
  .div_q      (div_q),
  .main_half  (main_half),
  .aux_func   (aux_func),
  .pll_bypass (pll_bypass),
  .pd_n       (pd_n),
  .main_clk_o (main_clk_o),
  .aux_clk_o  (aux_clk_o),
  .pad_oe_o   (pad_oe_o)
);

// File: tb/clk_out_divsel_tb_top.sv
`timescale 1ns/100ps
module clk_out_divsel_tb_top;
  logic       vco_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic [2:0] div_sel = 3'b011;
  logic [1:0] aux_func = 2'b11;
  logic       pll_bypass = 1'b0;
  logic       pd_n = 1'b1;
  logic       main_clk_o, aux_clk_o, pad_oe_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int ref_edges = 0;

  clk_out_divsel dut_i (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .div_sel(div_sel), .aux_func(aux_func), .pll_bypass(pll_bypass),
    .pd_n(pd_n), .main_clk_o(main_clk_o), .aux_clk_o(aux_clk_o),
    .pad_oe_o(pad_oe_o)
  );

  always #10 vco_clk = ~vco_clk;
  initial begin
    #3.5;
    forever #17 ref_clk = ~ref_clk;
  end

  always @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) ref_edges <= 0;
    else        ref_edges <= ref_edges + 1;
  end

  function automatic int ratio_exp(input logic [2:0] c);
    case (c)
      3'b000: return 10; 3'b001: return 2; 3'b010: return 8; 3'b011: return 4;
      3'b100: return 5;  3'b101: return 7; 3'b110: return 3; default: return 6;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic smp(input bit which);
    return which ? aux_clk_o : main_clk_o;
  endfunction

  task automatic count_runs(input bit which, output int hi, output int lo);
    hi = 1;
    forever begin
      @(negedge vco_clk);
      if (!smp(which) || hi > 200) break;
      hi++;
    end
    lo = 1;
    forever begin
      @(negedge vco_clk);
      if (smp(which) || lo > 200) break;
      lo++;
    end
  endtask

  task automatic find_rise(input bit which);
    logic p;
    int g;
    p = smp(which);
    g = 0;
    forever begin
      @(negedge vco_clk);
      g++;
      if ((smp(which) && !p) || g > 200) break;
      p = smp(which);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge vco_clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi, lo, h2, l2, mism;
    logic [4:0] pat_m, pat_a;

    // R10: outputs quiet during reset
    idle(3);
    chk("R10", "main low in reset", main_clk_o, 0);
    chk("R10", "main-half aux low in reset", aux_clk_o, 0);
    chk("R9", "pad enable with pd_n high", pad_oe_o, 1);

    // R10 / R7: first periods after release, ratio 4
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge vco_clk);
      pat_m[4-i] = main_clk_o;
      pat_a[4-i] = aux_clk_o;
    end
    chk("R10", "main pattern after release", pat_m, 5'b11001);
    chk("R7", "half pattern after release", pat_a, 5'b11110);

    // R1 / R2: sweep all select codes
    for (int s = 0; s < 8; s++) begin
      div_sel = 3'(s);
      idle(25);
      find_rise(1'b0);
      count_runs(1'b0, hi, lo);
      chk("R1", $sformatf("period sel=%0d", s), hi + lo, ratio_exp(3'(s)));
      chk("R2", $sformatf("high run sel=%0d", s), hi, ratio_exp(3'(s)) / 2);
    end

    // R3: change mid-period from ratio 10 to ratio 2
    div_sel = 3'b000;
    idle(25);
    find_rise(1'b0);
    div_sel = 3'b001;
    count_runs(1'b0, hi, lo);
    count_runs(1'b0, h2, l2);
    chk("R3", "old high run", hi, 5);
    chk("R3", "old low run", lo, 5);
    chk("R3", "new high run", h2, 1);
    chk("R3", "new low run", l2, 1);

    // R7: main halved, odd and even ratio
    aux_func = 2'b11;
    div_sel = 3'b100;
    idle(30);
    find_rise(1'b1);
    count_runs(1'b1, hi, lo);
    chk("R7", "half high sel=4", hi, 5);
    chk("R7", "half low sel=4", lo, 5);
    div_sel = 3'b010;
    idle(40);
    find_rise(1'b1);
    chk("R7", "half rises with main", main_clk_o, 1);
    count_runs(1'b1, hi, lo);
    chk("R7", "half high sel=2", hi, 8);
    chk("R7", "half low sel=2", lo, 8);

    // R4: aux follows reference
    aux_func = 2'b00;
    mism = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge vco_clk);
      if (aux_clk_o !== ref_clk) mism++;
    end
    chk("R4", "aux vs ref mismatches", mism, 0);

    // R5: aux is reference halved
    aux_func = 2'b01;
    mism = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge vco_clk);
      if (aux_clk_o !== ref_edges[0]) mism++;
    end
    chk("R5", "aux vs ref edge parity mismatches", mism, 0);

    // R6: held low while main keeps running
    aux_func = 2'b10;
    mism = 0;
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge vco_clk);
      if (aux_clk_o !== 1'b0) mism++;
      if (main_clk_o) hi++;
    end
    chk("R6", "aux high samples", mism, 0);
    chk("R6", "main high samples with ratio 8", hi, 20);

    // R8: bypass overrides both
    aux_func = 2'b01;
    div_sel = 3'b110;
    pll_bypass = 1'b1;
    mism = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge vco_clk);
      if (main_clk_o !== ref_clk || aux_clk_o !== ref_clk) mism++;
    end
    chk("R8", "bypass mismatches", mism, 0);
    pll_bypass = 1'b0;

    // R9: power-down silences outputs
    aux_func = 2'b00;
    pd_n = 1'b0;
    mism = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge vco_clk);
      if (main_clk_o || aux_clk_o || pad_oe_o) mism++;
    end
    chk("R9", "power-down active samples", mism, 0);
    pd_n = 1'b1;
    @(negedge vco_clk);
    chk("R9", "pad enable restored", pad_oe_o, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule